// File: doc/BRIEF.md
# Synchronous Serial Audio/Telecom Port

The block is one channel of a synchronous serial port with a transmit path and a receive path. The host pushes data words into an 8-entry transmit buffer and pops received words from an 8-entry receive buffer, both over a valid/ready handshake. The transmitter sends each word on a serial data line, with a word length of 3 to 32 bits and a selectable bit order. The receiver rebuilds words from the serial input line and places them in its buffer.

The serial clock comes from an internal divider of the system clock, or it is taken from an external pin. Transmit data changes on the rising serial clock edge. Receive data and the incoming frame sync are sampled at the falling edge. The transmitter always generates the frame timing and runs frames back to back while the port is enabled, with one idle bit slot between words. The frame sync can be early or late, active high or active low, and one bit long or one word long. The receiver aligns to that internal frame sync or to a frame sync taken from a pin. Configuration inputs are expected to stay static while the port is enabled.

Each completed word raises a one-cycle interrupt pulse. Sticky flags record transmit underflow and receive overflow. Both flags clear while the port is disabled.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, and whenever `en_i` is low, `fs_o` sits at its inactive level (equal to `fs_low_i`), `sd_o` and `sclk_o` are low, `tx_ready_o` is high while the transmit buffer has room, and both sticky flags are low.
- R2: With `sclk_int_i`=1 the serial clock period is 2×(`div_i`+1) system clocks, and `sclk_o` idles low before the first rising edge.
- R3: A word is `wlen_m1_i`+1 bits long. Values of `wlen_m1_i` below 2 act as 2, so the shortest word is 3 bits. Transmit bits above the word length are not sent, and received words carry zeros above the word length.
- R4: With `lsb_first_i`=0 the word is sent most significant bit first. With `lsb_first_i`=1 bit 0 is sent first. The receiver uses the same order.
- R5: A frame is word length plus one slot long (one idle slot, then the data slots), and slots advance on rising serial clock edges. `fs_late_i`=1, `fs_long_i`=0: the pulse covers the first data slot. Late and long: it covers all data slots. Early and short: it covers the idle slot. Early and long: it covers the idle slot and every data slot except the last.
- R6: `fs_low_i`=1 inverts `fs_o` and the sense expected on `fs_i`.
- R7: With `fs_int_i`=0 the receiver aligns only to `fs_i`. A transition to active seen at a falling edge marks the first data bit at that edge (late) or at the next falling edge (early). With `fs_i` held inactive, no word is received.
- R8: With `sclk_int_i`=0 all bit timing follows rising and falling edges of `sclk_i`.
- R9: The transmit buffer holds 8 words, and `tx_ready_o` drops when it is full. Words may be loaded while the port is disabled.
- R10: The receive buffer holds 8 words. A word completed while it is full is dropped, and `rx_orun_o` is set.
- R11: If the transmit buffer is empty when a frame starts, the previous word is sent again and `tx_urun_o` is set.
- R12: `tx_irq_o` pulses for one cycle after each sent word. `rx_irq_o` pulses for one cycle after each word stored in the receive buffer.
- R13: Sticky flags stay set while enabled and clear once `en_i` is low.
- R14: While `rx_valid_o` is high and `rx_ready_i` is low, `rx_valid_o` and `rx_data_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| div_i | input | 16 | Serial clock divider value |
| wlen_m1_i | input | 5 | Word length minus one |
| lsb_first_i | input | 1 | Bit order select |
| sclk_int_i | input | 1 | 1: internal serial clock, 0: use sclk_i |
| fs_int_i | input | 1 | 1: receiver uses internal frame sync, 0: uses fs_i |
| fs_low_i | input | 1 | Frame sync active low |
| fs_late_i | input | 1 | Late frame sync |
| fs_long_i | input | 1 | Word-long frame sync pulse |
| sclk_i | input | 1 | External serial clock |
| sclk_o | output | 1 | Internal serial clock |
| fs_i | input | 1 | External frame sync |
| fs_o | output | 1 | Generated frame sync |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |
| tx_data_i | input | 32 | Transmit word |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Transmit buffer has room |
| rx_data_o | output | 32 | Received word |
| rx_valid_o | output | 1 | Received word available |
| rx_ready_i | input | 1 | Host takes received word |
| tx_irq_o | output | 1 | Word sent pulse |
| rx_irq_o | output | 1 | Word received pulse |
| tx_urun_o | output | 1 | Sticky transmit underflow |
| rx_orun_o | output | 1 | Sticky receive overflow |

## Verification
The assertions check on every cycle that the flags stay sticky while enabled, that interrupts are single-cycle pulses, that a held receive word stays stable, and that the serial outputs go quiet when disabled. Slot-level frame sync shapes, bit order, word masking, divider period, underflow repetition, overflow dropping and alignment to an external frame sync or serial clock depend on multi-frame sequences. Only the bench scenarios show these, by sampling `fs_o` and `sd_o` at every rising serial edge and by looping `sd_o` back to `sd_i`.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned MIN_LAST = 2;

  // Position in the word of the bit carried by slot pos
  function automatic int unsigned bit_idx(int unsigned pos, int unsigned last, logic lsb_first);
    return lsb_first ? pos : (last - pos);
  endfunction
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             int_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             drive_o,
  output logic             sample_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic [2:0]       sync_q;
  logic             tick, ext_rise, ext_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sclk_i};
      if (!en_i || !int_i) begin
        cnt_q  <= '0;
        sclk_q <= 1'b0;
      end else if (cnt_q == div_i) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick     = en_i && int_i && (cnt_q == div_i);
  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign ext_fall = ~sync_q[1] & sync_q[2];
  assign drive_o  = int_i ? (tick && !sclk_q) : (en_i && ext_rise);
  assign sample_o = int_i ? (tick && sclk_q)  : (en_i && ext_fall);
  assign sclk_o   = sclk_q;
endmodule

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8   // power of two
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wr_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i && !full_o)  wr_q <= wr_q + 1'b1;
      if (pop_i  && !empty_o) rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wr_q[AW-1:0]] <= wdata_i;
  end

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign rdata_o = mem_q[rd_q[AW-1:0]];
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx import ssp_pkg::*; #(
  parameter int W  = 32,
  parameter int LW = $clog2(W),
  parameter int SW = LW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          drive_i,
  input  logic [LW-1:0] last_i,
  input  logic          lsb_first_i,
  input  logic          late_i,
  input  logic          long_i,
  input  logic          fifo_empty_i,
  input  logic [W-1:0]  fifo_data_i,
  output logic          fifo_pop_o,
  output logic          fs_act_o,
  output logic          sd_o,
  output logic          irq_o,
  output logic          urun_o
);
  logic [SW-1:0] slot_q, idle_slot, last_slot;
  logic          run_q, loaded_q, irq_q, urun_q;
  logic [W-1:0]  word_q;
  logic          at_idle, at_last, load, fs_raw;
  logic [LW-1:0] idx;

  assign last_slot = {1'b0, last_i};
  assign idle_slot = last_slot + SW'(1);
  assign at_idle   = (slot_q == idle_slot);
  assign at_last   = (slot_q == last_slot);
  assign load      = drive_i && run_q && at_idle;
  assign idx       = LW'(bit_idx(int'(slot_q[LW-1:0]), int'(last_i), lsb_first_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
      irq_q    <= 1'b0;
      urun_q   <= 1'b0;
      word_q   <= '0;
    end else if (!en_i) begin
      slot_q   <= '0;
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
      irq_q    <= 1'b0;
      urun_q   <= 1'b0;   // R13
    end else begin
      irq_q <= drive_i && run_q && at_last && loaded_q;  // R12
      if (drive_i) begin
        if (!run_q) begin
          run_q  <= 1'b1;
          slot_q <= idle_slot;
        end else if (at_idle) begin
          slot_q <= '0;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
      if (load) begin
        loaded_q <= 1'b1;
        if (fifo_empty_i) urun_q <= 1'b1;   // R11: word_q kept, resent
        else              word_q <= fifo_data_i;
      end
    end
  end

  // R5 slot layout of the frame sync pulse
  always_comb begin
    unique case ({late_i, long_i})
      2'b10:   fs_raw = (slot_q == '0);
      2'b11:   fs_raw = !at_idle;
      2'b00:   fs_raw = at_idle;
      default: fs_raw = at_idle || (slot_q < last_slot);
    endcase
  end

  assign fs_act_o   = run_q && fs_raw;
  assign sd_o       = run_q && loaded_q && !at_idle && word_q[idx];
  assign fifo_pop_o = load && !fifo_empty_i;
  assign irq_o      = irq_q;
  assign urun_o     = urun_q;
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx import ssp_pkg::*; #(
  parameter int W  = 32,
  parameter int LW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sample_i,
  input  logic [LW-1:0] last_i,
  input  logic          lsb_first_i,
  input  logic          late_i,
  input  logic          fsa_i,
  input  logic          sd_i,
  input  logic          fifo_full_i,
  output logic          push_o,
  output logic [W-1:0]  word_o,
  output logic          irq_o,
  output logic          orun_o
);
  logic          fs_prev_q, busy_q, irq_q, orun_q;
  logic [LW-1:0] cnt_q, pos;
  logic [W-1:0]  acc_q, acc_nxt;
  logic          start, done;

  assign start = fsa_i && !fs_prev_q;   // R7 active transition
  assign pos   = start ? '0 : cnt_q;
  assign done  = en_i && sample_i && busy_q && !start && (cnt_q == last_i);

  always_comb begin
    acc_nxt = start ? '0 : acc_q;
    acc_nxt[LW'(bit_idx(int'(pos), int'(last_i), lsb_first_i))] = sd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_prev_q <= 1'b0;
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
      irq_q     <= 1'b0;
      orun_q    <= 1'b0;
    end else if (!en_i) begin
      fs_prev_q <= 1'b0;
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      irq_q     <= 1'b0;
      orun_q    <= 1'b0;   // R13
    end else begin
      irq_q <= done && !fifo_full_i;        // R12
      if (done && fifo_full_i) orun_q <= 1'b1;  // R10
      if (sample_i) begin
        fs_prev_q <= fsa_i;
        if (start) begin
          busy_q <= 1'b1;
          if (late_i) begin
            acc_q <= acc_nxt;
            cnt_q <= LW'(1);
          end else begin
            acc_q <= '0;
            cnt_q <= '0;
          end
        end else if (busy_q) begin
          acc_q <= acc_nxt;
          if (cnt_q == last_i) busy_q <= 1'b0;
          else                 cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign push_o = done && !fifo_full_i;
  assign word_o = acc_nxt;
  assign irq_o  = irq_q;
  assign orun_o = orun_q;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port import ssp_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16,
  localparam int LW        = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [LW-1:0]     wlen_m1_i,
  input  logic              lsb_first_i,
  input  logic              sclk_int_i,
  input  logic              fs_int_i,
  input  logic              fs_low_i,
  input  logic              fs_late_i,
  input  logic              fs_long_i,
  input  logic              sclk_i,
  output logic              sclk_o,
  input  logic              fs_i,
  output logic              fs_o,
  input  logic              sd_i,
  output logic              sd_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              tx_urun_o,
  output logic              rx_orun_o
);
  logic [LW-1:0]     last;
  logic              drive, sample;
  logic              txf_full, txf_empty, txf_pop;
  logic [DATA_W-1:0] txf_data;
  logic              rxf_full, rxf_empty, rxf_push;
  logic [DATA_W-1:0] rxf_wdata;
  logic              fs_act, rx_fsa;

  // R3: shortest word is three bits
  assign last = (wlen_m1_i < LW'(MIN_LAST)) ? LW'(MIN_LAST) : wlen_m1_i;

  ssp_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i, .rst_ni, .en_i, .int_i(sclk_int_i), .div_i, .sclk_i,
    .sclk_o, .drive_o(drive), .sample_o(sample)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i, .rst_ni, .push_i(tx_valid_i), .wdata_i(tx_data_i),
    .pop_i(txf_pop), .rdata_o(txf_data), .full_o(txf_full), .empty_o(txf_empty)
  );

  ssp_tx #(.W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .en_i, .drive_i(drive), .last_i(last),
    .lsb_first_i, .late_i(fs_late_i), .long_i(fs_long_i),
    .fifo_empty_i(txf_empty), .fifo_data_i(txf_data), .fifo_pop_o(txf_pop),
    .fs_act_o(fs_act), .sd_o, .irq_o(tx_irq_o), .urun_o(tx_urun_o)
  );

  assign rx_fsa = fs_int_i ? fs_act : (fs_i ^ fs_low_i);   // R6, R7

  ssp_rx #(.W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .en_i, .sample_i(sample), .last_i(last),
    .lsb_first_i, .late_i(fs_late_i), .fsa_i(rx_fsa), .sd_i,
    .fifo_full_i(rxf_full), .push_o(rxf_push), .word_o(rxf_wdata),
    .irq_o(rx_irq_o), .orun_o(rx_orun_o)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i, .rst_ni, .push_i(rxf_push), .wdata_i(rxf_wdata),
    .pop_i(rx_ready_i), .rdata_o(rx_data_o), .full_o(rxf_full), .empty_o(rxf_empty)
  );

  assign fs_o       = fs_act ^ fs_low_i;
  assign tx_ready_o = !txf_full;
  assign rx_valid_o = !rxf_empty;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              fs_low_i,
  input logic              fs_o,
  input logic              sd_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic              tx_irq_o,
  input logic              rx_irq_o,
  input logic              tx_urun_o,
  input logic              rx_orun_o
);
  AST_FS_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (fs_o == fs_low_i)); // R1
  AST_SD_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sd_o); // R1
  AST_URUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_urun_o && en_i) |=> tx_urun_o); // R11
  AST_ORUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_orun_o && en_i) |=> rx_orun_o); // R10
  AST_TX_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o); // R12
  AST_RX_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o); // R12
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o))); // R14
endmodule

bind sync_serial_port ssp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .fs_low_i(fs_low_i),
  .fs_o(fs_o), .sd_o(sd_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
  .rx_ready_i(rx_ready_i), .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o),
  .tx_urun_o(tx_urun_o), .rx_orun_o(rx_orun_o)
);

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        en = 0, lsb = 0, sclkint = 1, fsint = 1, low = 0, late = 1, lng = 0;
  logic [15:0] div = 16'd1;
  logic [4:0]  wm1 = 5'd7;
  logic        sclk_in = 0, fs_ext = 0, fs_loop = 1, ext_on = 0;
  logic [31:0] tx_data = '0;
  logic        tx_valid = 0, rx_ready = 0;
  wire         sclk_o, fs_o, sd_o, tx_ready, rx_valid, tx_irq, rx_irq, urun, orun;
  wire [31:0]  rx_data;
  wire         fs_in = fs_loop ? fs_o : fs_ext;

  int checks = 0, errors = 0, tx_irqs = 0, rx_irqs = 0;

  sync_serial_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div), .wlen_m1_i(wm1),
    .lsb_first_i(lsb), .sclk_int_i(sclkint), .fs_int_i(fsint), .fs_low_i(low),
    .fs_late_i(late), .fs_long_i(lng), .sclk_i(sclk_in), .sclk_o(sclk_o),
    .fs_i(fs_in), .fs_o(fs_o), .sd_i(sd_o), .sd_o(sd_o),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .tx_urun_o(urun), .rx_orun_o(orun)
  );

  always @(negedge clk) begin
    if (tx_irq) tx_irqs++;
    if (rx_irq) rx_irqs++;
  end

  initial begin : ext_clock
    forever begin
      repeat (3) @(negedge clk);
      if (ext_on) sclk_in = ~sclk_in;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(input logic [4:0] m, input logic [31:0] w);
    int len = (m < 2) ? 3 : int'(m) + 1;
    return (len == 32) ? w : (w & ((32'd1 << len) - 1));
  endfunction

  task automatic cfg(input logic [4:0] m, input logic l, input logic lt, input logic lg, input logic lo);
    @(negedge clk);
    en = 0; wm1 = m; lsb = l; late = lt; lng = lg; low = lo;
  endtask

  task automatic push(input logic [31:0] w);
    tx_valid = 1; tx_data = w;
    forever begin
      if (tx_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    tx_valid = 0;
  endtask

  task automatic pop_expect(input logic [31:0] exp, input string tag);
    for (int i = 0; i < 4000 && !rx_valid; i++) @(negedge clk);
    check(rx_valid && rx_data == exp, tag, rx_data, exp);
    rx_ready = 1; @(negedge clk); rx_ready = 0;
  endtask

  task automatic wait_tx_irqs(input int n);
    for (int i = 0; i < 20000 && tx_irqs < n; i++) @(negedge clk);
  endtask

  task automatic stop_and_drain;
    en = 0;
    @(negedge clk);
    rx_ready = 1; repeat (12) @(negedge clk); rx_ready = 0;
  endtask

  // three words through the loopback
  task automatic run_loop(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c, input string tag);
    push(a); push(b); push(c);
    tx_irqs = 0; rx_irqs = 0;
    en = 1;
    wait_tx_irqs(3);
    check(!urun, {tag, " no underflow"}, urun, 0);
    en = 0;
    pop_expect(mask(wm1, a), tag);
    pop_expect(mask(wm1, b), tag);
    pop_expect(mask(wm1, c), tag);
    check(rx_irqs == 3 && tx_irqs == 3, "R12 irq count", rx_irqs, 3);
    check(!rx_valid, {tag, " no extra word"}, rx_valid, 0);
  endtask

  // record fs_o and sd_o for 10 slots after each rising sclk_o
  task automatic capture(input logic [31:0] w, output logic [9:0] fsv, output logic [9:0] sdv);
    push(w);
    en = 1;
    for (int s = 0; s < 10; s++) begin
      @(posedge sclk_o); #1;
      fsv[s] = fs_o; sdv[s] = sd_o;
    end
    @(negedge clk);
    stop_and_drain();
  endtask

  task automatic test_reset;
    check(tx_ready && !rx_valid, "R1 reset ready/valid", {tx_ready, rx_valid}, 2'b10);
    check(!fs_o && !sd_o && !sclk_o, "R1 reset serial lines", {fs_o, sd_o, sclk_o}, 0);
    check(!urun && !orun, "R1 reset flags", {urun, orun}, 0);
  endtask

  task automatic measure(input logic [15:0] d, input int exp);
    int n = 0;
    logic prev;
    @(negedge clk); div = d; en = 1;
    prev = sclk_o;
    forever begin @(negedge clk); if (sclk_o && !prev) break; prev = sclk_o; end
    prev = sclk_o;
    forever begin
      @(negedge clk); n++;
      if (sclk_o && !prev) break;
      prev = sclk_o;
    end
    check(n == exp, "R2 sclk period", n, exp);
    stop_and_drain();
    div = 16'd1;
  endtask

  task automatic test_period;
    measure(16'd3, 8);
    measure(16'd0, 2);
  endtask

  task automatic test_lengths;
    cfg(5'd7, 0, 1, 0, 0);  run_loop(32'hA5, 32'h3C, 32'h1FF, "R3 wlen8");
    cfg(5'd31, 0, 1, 0, 0); run_loop(32'hDEADBEEF, 32'h80000001, 32'h12345678, "R3 wlen32");
    cfg(5'd2, 1, 0, 0, 0);  run_loop(32'hFF, 32'h2, 32'h5, "R3 wlen3");
    cfg(5'd0, 0, 1, 0, 0);  run_loop(32'h1D, 32'h3, 32'h6, "R3 clamp");
  endtask

  task automatic test_waveforms;
    logic [9:0] f, d;
    cfg(5'd7, 0, 1, 0, 0); capture(32'hB1, f, d);
    check(d == 10'h11A, "R4 msb first bits", d, 10'h11A);
    check(f == 10'h002, "R5 late short fs", f, 10'h002);
    cfg(5'd7, 1, 1, 0, 0); capture(32'hB1, f, d);
    check(d == 10'h162, "R4 lsb first bits", d, 10'h162);
    cfg(5'd7, 0, 0, 0, 0); capture(32'hB1, f, d);
    check(f == 10'h201, "R5 early short fs", f, 10'h201);
    check(d == 10'h11A, "R5 early data slots", d, 10'h11A);
    cfg(5'd7, 0, 1, 1, 0); capture(32'hB1, f, d);
    check(f == 10'h1FE, "R5 late long fs", f, 10'h1FE);
    cfg(5'd7, 0, 0, 1, 0); capture(32'hB1, f, d);
    check(f == 10'h2FF, "R5 early long fs", f, 10'h2FF);
    cfg(5'd7, 0, 1, 0, 1);
    @(negedge clk);
    check(fs_o == 1'b1, "R6 idle level active-low", fs_o, 1);
    capture(32'hB1, f, d);
    check(f == 10'h3FD, "R6 inverted late short", f, 10'h3FD);
    cfg(5'd7, 1, 0, 1, 1); run_loop(32'h5A, 32'hC3, 32'h01, "R6 loop active-low");
  endtask

  task automatic test_ext_fs;
    cfg(5'd7, 0, 1, 0, 0);
    fsint = 0; fs_loop = 0; fs_ext = 0;
    push(32'h77);
    tx_irqs = 0; rx_irqs = 0; en = 1;
    wait_tx_irqs(2);
    check(!rx_valid && rx_irqs == 0, "R7 no frame no word", rx_valid, 0);
    stop_and_drain();
    fs_loop = 1;
    run_loop(32'h11, 32'hEE, 32'h42, "R7 external fs late");
    cfg(5'd15, 0, 0, 0, 0);
    run_loop(32'hBEEF, 32'h0F0F, 32'h8001, "R7 external fs early");
    fsint = 1;
  endtask

  task automatic test_ext_sclk;
    cfg(5'd9, 1, 1, 0, 0);
    sclkint = 0; ext_on = 1;
    run_loop(32'h2AB, 32'h155, 32'h3FF, "R8 external sclk");
    check(!sclk_o, "R8 sclk_o idle", sclk_o, 0);
    ext_on = 0; sclkint = 1;
  endtask

  task automatic test_overflow;
    logic [31:0] d0;
    cfg(5'd7, 0, 1, 0, 0);
    for (int i = 0; i < 8; i++) push(32'h10 + i);
    @(negedge clk);
    check(!tx_ready, "R9 tx full after 8", tx_ready, 0);
    tx_irqs = 0; en = 1;
    push(32'h18);
    wait_tx_irqs(9);
    check(orun, "R10 overflow flag", orun, 1);
    d0 = rx_data;
    repeat (5) @(negedge clk);
    check(rx_valid && rx_data == d0, "R14 held word", rx_data, d0);
    check(orun, "R13 flag held while enabled", orun, 1);
    en = 0;
    @(negedge clk);
    check(!orun, "R13 overflow cleared", orun, 0);
    for (int i = 0; i < 8; i++) pop_expect(32'h10 + i, "R10 kept words");
    check(!rx_valid, "R10 ninth dropped", rx_valid, 0);
  endtask

  task automatic test_underflow;
    cfg(5'd7, 0, 1, 0, 0);
    push(32'h81); push(32'h42);
    tx_irqs = 0; en = 1;
    wait_tx_irqs(3);
    check(urun, "R11 underflow flag", urun, 1);
    en = 0;
    @(negedge clk);
    check(!urun, "R13 underflow cleared", urun, 0);
    pop_expect(32'h81, "R11 first");
    pop_expect(32'h42, "R11 second");
    pop_expect(32'h42, "R11 repeated");
    stop_and_drain();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_period();
    test_lengths();
    test_waveforms();
    test_ext_fs();
    test_ext_sclk();
    test_overflow();
    test_underflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule